// File: doc/BRIEF.md
# Packed Lane Average / Absolute Difference / Min-Max Unit

This unit performs SIMD integer arithmetic on a 64-bit word that is split into independent lanes. It can split the word into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. In every lane it computes one of four operations: a rounded average, an unsigned absolute difference, a maximum or a minimum. The maximum and the minimum compare the lanes either as signed or as unsigned values. The average also honours the signed flag, which decides how each lane is extended before the sum is taken.

No carry, borrow or comparison result ever moves from one lane to the next. The unit accepts one operation per cycle when `valid_i` is high. It registers the result and presents it on the following cycle. The result register keeps its value on every cycle in which no new operation is issued.

Top module: `lane_arith_unit`

## Requirements
- R1: `valid_o` is high in the cycle after a rising clock edge at which `valid_i` was high, and low after an edge at which `valid_i` was low. At an edge with `valid_i` high, `result_o` takes the result computed from the operands sampled at that edge.
- R2: When `valid_i` is low at an edge, `result_o` keeps its previous value, whatever the other inputs are.
- R3: While `rst_ni` is low, `valid_o` is 0 and `result_o` is 0.
- R4: `width_i` selects the lane width: 00 gives 8 bits, 01 gives 16 bits and 10 gives 32 bits. Lane k occupies bits [k*W +: W]. No carry or borrow crosses a lane boundary.
- R5: Opcode 00 is the average. Each lane's result is ((a + b + 1) >> 1) truncated to W bits, computed without overflow. The operands are sign-extended when `signed_i` = 1 and zero-extended when it is 0.
- R6: Opcode 01 is the absolute difference. It returns a-b when a > b and b-a otherwise, both unsigned, and `signed_i` has no effect on it.
- R7: Opcode 10 is the maximum. It returns a when a > b and b otherwise. The comparison is signed when `signed_i` = 1 and unsigned when it is 0.
- R8: Opcode 11 is the minimum. It returns a when a < b and b otherwise, with signedness chosen as in R7.
- R9: `width_i` = 11 behaves exactly like 10 (32-bit lanes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue an operation this cycle |
| a_i | input | 64 | First operand word |
| b_i | input | 64 | Second operand word |
| width_i | input | 2 | Lane width select |
| op_i | input | 2 | Operation select |
| signed_i | input | 1 | Signed lanes for average, max and min |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Packed result word |

## Verification
A lane-select or carry-isolation fault shows up as damage in a single lane. A typical example is a carry leaking out of one byte of an all-ones average, which corrupts the neighbouring byte. The fault is visible on `result_o` one cycle after the offending operation. A fault in the sign handling shows up only in lanes whose top bit is set, so the directed cases set the MSB of every lane. Faults in the hold or valid path are visible in the first idle cycle as a changed `result_o` or a wrong `valid_o`.

// File: rtl/lane_arith_pkg.sv
package lane_arith_pkg;
  typedef enum logic [1:0] {
    OP_AVG  = 2'b00,
    OP_ABSD = 2'b01,
    OP_MAX  = 2'b10,
    OP_MIN  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    LW_8  = 2'b00,
    LW_16 = 2'b01,
    LW_32 = 2'b10,
    LW_RSV = 2'b11
  } lw_e;
endpackage

// File: rtl/lane_core.sv
module lane_core
  import lane_arith_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  op_e          op_i,
  input  logic         signed_i,
  output logic [W-1:0] y_o
);
  logic [W:0]   a_ext, b_ext;
  logic [W-1:0] avg, absd;
  logic         s_gt, s_lt, u_gt;

  // one guard bit: sign or zero extension
  assign a_ext = {signed_i & a_i[W-1], a_i};
  assign b_ext = {signed_i & b_i[W-1], b_i};

  // (a+b+1)>>1 == (a>>1)+(b>>1)+(a0|b0); never overflows W bits
  assign avg = a_ext[W:1] + b_ext[W:1] + {{(W-1){1'b0}}, a_ext[0] | b_ext[0]};

  assign u_gt = a_i > b_i;
  assign absd = u_gt ? (a_i - b_i) : (b_i - a_i);

  assign s_gt = $signed(a_ext) > $signed(b_ext);
  assign s_lt = $signed(a_ext) < $signed(b_ext);

  always_comb begin
    unique case (op_i)
      OP_AVG:  y_o = avg;
      OP_ABSD: y_o = absd;
      OP_MAX:  y_o = s_gt ? a_i : b_i;
      default: y_o = s_lt ? a_i : b_i;
    endcase
  end
endmodule

// File: rtl/lane_bank.sv
module lane_bank
  import lane_arith_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  op_e               op_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int NLANES = DATA_W / LANE_W;

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    lane_core #(.W(LANE_W)) u_core (
      .a_i      (a_i[k*LANE_W +: LANE_W]),
      .b_i      (b_i[k*LANE_W +: LANE_W]),
      .op_i     (op_i),
      .signed_i (signed_i),
      .y_o      (y_o[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/lane_arith_unit.sv
module lane_arith_unit
  import lane_arith_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        width_i,
  input  logic [1:0]        op_i,
  input  logic              signed_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int NW = 3;
  localparam int LANE_W [NW] = '{8, 16, 32};

  op_e               op;
  logic [DATA_W-1:0] bank_y [NW];
  logic [DATA_W-1:0] sel_y;

  assign op = op_e'(op_i);

  for (genvar g = 0; g < NW; g++) begin : g_bank
    lane_bank #(.DATA_W(DATA_W), .LANE_W(LANE_W[g])) u_bank (
      .a_i      (a_i),
      .b_i      (b_i),
      .op_i     (op),
      .signed_i (signed_i),
      .y_o      (bank_y[g])
    );
  end

  always_comb begin
    unique case (lw_e'(width_i))
      LW_8:    sel_y = bank_y[0];
      LW_16:   sel_y = bank_y[1];
      default: sel_y = bank_y[2]; // R9: reserved code maps to 32-bit lanes
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= sel_y;
    end
  end
endmodule

// File: rtl/lane_arith_chk.sv
module lane_arith_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [1:0]        width_i,
  input logic [1:0]        op_i,
  input logic              signed_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  logic issue_max8u, issue_min8u, issue_avg16u, issue_abs32;
  assign issue_max8u  = valid_i && op_i == 2'b10 && !signed_i && width_i == 2'b00;
  assign issue_min8u  = valid_i && op_i == 2'b11 && !signed_i && width_i == 2'b00;
  assign issue_avg16u = valid_i && op_i == 2'b00 && !signed_i && width_i == 2'b01;
  assign issue_abs32  = valid_i && op_i == 2'b01 && width_i == 2'b10;

  p_valid_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  for (genvar k = 0; k < DATA_W/8; k++) begin : g_b8
    p_max_ge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_max8u |=> (result_o[k*8 +: 8] >= $past(a_i[k*8 +: 8])) &&
                      (result_o[k*8 +: 8] >= $past(b_i[k*8 +: 8])));
    p_min_le_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_min8u |=> (result_o[k*8 +: 8] <= $past(a_i[k*8 +: 8])) &&
                      (result_o[k*8 +: 8] <= $past(b_i[k*8 +: 8])));
  end

  for (genvar k = 0; k < DATA_W/16; k++) begin : g_b16
    p_avg_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_avg16u |=>
        ((result_o[k*16 +: 16] >= $past(a_i[k*16 +: 16])) ||
         (result_o[k*16 +: 16] >= $past(b_i[k*16 +: 16]))) &&
        ((result_o[k*16 +: 16] <= $past(a_i[k*16 +: 16])) ||
         (result_o[k*16 +: 16] <= $past(b_i[k*16 +: 16]))));
  end

  for (genvar k = 0; k < DATA_W/32; k++) begin : g_b32
    p_abs_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_abs32 |=> (result_o[k*32 +: 32] <= $past(a_i[k*32 +: 32])) ||
                      (result_o[k*32 +: 32] <= $past(b_i[k*32 +: 32])));
  end
endmodule

bind lane_arith_unit lane_arith_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .width_i  (width_i),
  .op_i     (op_i),
  .signed_i (signed_i),
  .valid_o  (valid_o),
  .result_o (result_o)
);

// File: tb/lane_arith_unit_test.sv
module lane_arith_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [1:0]  width_i = '0, op_i = '0;
  logic        signed_i = 1'b0;
  logic        valid_o;
  logic [63:0] result_o;

  int n_chk = 0, n_fail = 0;
  logic [63:0] last_res = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_arith_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .width_i(width_i), .op_i(op_i), .signed_i(signed_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                        logic [1:0] w, logic [1:0] op, logic s);
    int lw;
    longint mask, la, lb, xa, xb, r;
    logic [63:0] out;
    lw = (w == 2'b00) ? 8 : (w == 2'b01) ? 16 : 32;
    mask = (longint'(1) << lw) - 1;
    out = '0;
    for (int k = 0; k < 64 / lw; k++) begin
      la = longint'(a >> (k * lw)) & mask;
      lb = longint'(b >> (k * lw)) & mask;
      xa = la; xb = lb;
      if (s && la[lw-1]) xa = la - (longint'(1) << lw);
      if (s && lb[lw-1]) xb = lb - (longint'(1) << lw);
      case (op)
        2'b00: r = (xa + xb + 1) >>> 1;
        2'b01: r = (la > lb) ? la - lb : lb - la;
        2'b10: r = (s ? (xa > xb) : (la > lb)) ? la : lb;
        default: r = (s ? (xa < xb) : (la < lb)) ? la : lb;
      endcase
      out = out | (64'(r & mask) << (k * lw));
    end
    return out;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue at a falling edge, compare at the next falling edge (one register).
  task automatic issue(string req, logic [63:0] a, logic [63:0] b, logic [1:0] w,
                       logic [1:0] op, logic s, logic [63:0] exp);
    valid_i = 1'b1; a_i = a; b_i = b; width_i = w; op_i = op; signed_i = s;
    @(negedge clk);
    check({req, " value"}, result_o, exp);
    check("R1 valid_o high", {63'b0, valid_o}, 64'd1);
    last_res = result_o;
    valid_i = 1'b0;
  endtask

  task automatic op_chk(string req, logic [63:0] a, logic [63:0] b, logic [1:0] w,
                        logic [1:0] op, logic s);
    issue(req, a, b, w, op, s, model(a, b, w, op, s));
  endtask

  task automatic idle_chk();
    valid_i = 1'b0; a_i = {$urandom, $urandom}; b_i = {$urandom, $urandom};
    op_i = 2'($urandom); width_i = 2'($urandom); signed_i = 1'($urandom);
    @(negedge clk);
    check("R2 hold", result_o, last_res);
    check("R1 valid_o low", {63'b0, valid_o}, 64'd0);
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 6)
      0: return '1;
      1: return '0;
      2: return 64'h8080_8080_8080_8080;
      3: return 64'h7fff_7fff_8000_0001;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    // R3 reset state
    check("R3 reset valid_o", {63'b0, valid_o}, 64'd0);
    check("R3 reset result_o", result_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 unsigned byte average of all-ones with 0x01: no carry into neighbour (R4)
    issue("R5 R4 avg u8", '1, 64'h0101_0101_0101_0101, 2'b00, 2'b00, 1'b0,
          64'h8080_8080_8080_8080);
    idle_chk();
    // R5 signed: -128 + 0 rounds to -64
    issue("R5 avg s8", 64'h8080_8080_8080_8080, '0, 2'b00, 2'b00, 1'b1,
          64'hc0c0_c0c0_c0c0_c0c0);
    issue("R5 avg u8", 64'h8080_8080_8080_8080, '0, 2'b00, 2'b00, 1'b0,
          64'h4040_4040_4040_4040);
    issue("R5 avg u32 max", '1, '1, 2'b10, 2'b00, 1'b0, '1);
    // R6: signed flag ignored
    issue("R6 absd s8", '0, '1, 2'b00, 2'b01, 1'b1, '1);
    issue("R6 absd u16", 64'h0001_0005_ffff_0000, 64'h0003_0005_0000_ffff, 2'b01,
          2'b01, 1'b0, 64'h0002_0000_ffff_ffff);
    // R7 / R8 signed vs unsigned
    issue("R7 max s8", 64'h8080_8080_8080_8080, 64'h7f7f_7f7f_7f7f_7f7f, 2'b00,
          2'b10, 1'b1, 64'h7f7f_7f7f_7f7f_7f7f);
    issue("R7 max u8", 64'h8080_8080_8080_8080, 64'h7f7f_7f7f_7f7f_7f7f, 2'b00,
          2'b10, 1'b0, 64'h8080_8080_8080_8080);
    issue("R8 min s16", 64'h8000_0001_8000_0001, 64'h0001_8000_0001_8000, 2'b01,
          2'b11, 1'b1, 64'h8000_8000_8000_8000);
    issue("R8 min u32", 64'h8000_0000_0000_0001, 64'h0000_0001_ffff_ffff, 2'b10,
          2'b11, 1'b0, 64'h0000_0001_0000_0001);
    // R9 reserved width equals 32-bit lanes
    issue("R9 width 11 avg s", 64'h8000_0000_0000_0003, 64'h0000_0000_0000_0004,
          2'b11, 2'b00, 1'b1, 64'hc000_0000_0000_0004);
    idle_chk();

    for (int i = 0; i < 4000; i++) begin
      logic [63:0] ra, rb;
      logic [1:0]  rw, ro;
      logic        rs;
      ra = pick(); rb = pick(); rw = 2'($urandom); ro = 2'($urandom); rs = 1'($urandom);
      case (ro)
        2'b00: op_chk("R5 R4 random avg", ra, rb, rw, ro, rs);
        2'b01: op_chk("R6 R4 random absd", ra, rb, rw, ro, rs);
        2'b10: op_chk("R7 R4 random max", ra, rb, rw, ro, rs);
        default: op_chk("R8 R4 random min", ra, rb, rw, ro, rs);
      endcase
      if (rw == 2'b11) check("R9 width alias", model(ra, rb, 2'b11, ro, rs),
                             model(ra, rb, 2'b10, ro, rs));
      if ($urandom % 4 == 0) idle_chk();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule